// File: doc/BRIEF.md
# Serial Configuration Register Port

This block holds a configuration word of up to 48 bits and lets a host read or write it over a synchronous serial link. The block generates the serial clock itself. Two host lines choose what a session does. A register-select line, held high, opens a register session. A direction line, sampled when the session opens, picks read (high) or write (low). Write data is sampled from the transmit line on each rising serial clock edge. Read data is presented on the receive line so that it is steady at every rising edge. Bits always travel most significant first.

The word has a normal length of 24 bits. Bit 21 of the stored word switches on the extended 48-bit length. A write is kept only when its bit count matches a length allowed by the current contents. Otherwise it is dropped. A read returns 48 bits only when extended mode is on and bit 18 is also set; in every other case it returns 24 bits. Register sessions are possible only while the synchronous-mode input is high. When no register session is open, the receive line carries the demodulated data input unchanged.

Top module: `cfg_serial_port`

## Requirements
- R1: After reset the stored word equals the `CFG_DEFAULT` parameter (bit 21 clear, bit 18 set), the serial clock is low, and the busy and done flags are low.
- R2: The serial clock toggles only while a session is open. A session is open while register-select and synchronous-mode are both high. Each clock level lasts `HALF_DIV` cycles of `clk_i`, and the first rising edge comes `HALF_DIV` cycles after the session opens.
- R3: A write session with exactly 24 rising serial clock edges replaces stored bits 23..0. The first bit sampled lands in bit 23. Stored bits 47..24 are kept.
- R4: A write session whose count of rising edges is neither 24 nor an accepted 48 leaves the stored word unchanged.
- R5: A 48-bit write is accepted only when stored bit 21 is 1 at the end of the session. It then replaces all 48 bits, with the first bit sampled landing in bit 47. With bit 21 clear, a 48-bit write is dropped.
- R6: A read session gives exactly 48 rising edges when stored bits 21 and 18 are both 1, and exactly 24 otherwise. After that the serial clock stays low until the session closes. The bits come out most significant first, starting at bit 47 or at bit 23.
- R7: During a read session the receive line changes only in the cycle in which the serial clock falls. It never changes while the clock is high.
- R8: While synchronous-mode is low, register-select has no effect: no serial clock edge, busy stays low, and the stored word is unchanged.
- R9: Busy is high from the cycle after a session opens to the cycle after it closes. Done is high for exactly one cycle after each session closes.
- R10: Outside a read session, the receive line equals the demodulated data input in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_i | input | 1 | High when the link runs in synchronous mode; register access needs it |
| reg_sel_i | input | 1 | High opens a register session; low selects data traffic |
| rd_wr_i | input | 1 | Direction sampled at session open: 1 read, 0 write |
| txd_i | input | 1 | Serial write data from the host |
| dem_rxd_i | input | 1 | Demodulated data routed to the receive line outside reads |
| sclk_o | output | 1 | Serial clock generated by the block |
| rxd_o | output | 1 | Receive line: register bits during reads, demodulated data otherwise |
| busy_o | output | 1 | A register session is open |
| done_o | output | 1 | One-cycle pulse after a session closes |
| cfg_o | output | EXT_W | Current stored configuration word |

## Verification
A wrong bit counter shows up in the very read session where it occurs. The number of serial clock edges would differ from 24 or 48, or the clock would keep running after the last bit. A wrong shift direction or a wrong load alignment changes the readback of a walking-one pattern in its first read. A wrong commit rule shows on `cfg_o` within two cycles of the session closing, because writes of every nearby length (23, 25, 47, 49) are compared against the arithmetic model.

// File: rtl/ccp_pkg.sv
package ccp_pkg;
   typedef enum logic {
      DIR_WRITE = 1'b0,
      DIR_READ  = 1'b1
   } ccp_dir_e;
endpackage

// File: rtl/ccp_sclk_gen.sv
module ccp_sclk_gen #(
   parameter int HALF_DIV = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic en_i,
   output logic sclk_o,
   output logic rise_o,
   output logic fall_o
);
   logic tick;

   generate
      if (HALF_DIV == 1) begin : g_nodiv
         assign tick = en_i;
      end else begin : g_div
         localparam int DW = $clog2(HALF_DIV);
         localparam logic [DW-1:0] LAST = DW'(HALF_DIV - 1);
         logic [DW-1:0] cnt_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)                   cnt_q <= '0;
            else if (!en_i || cnt_q == LAST) cnt_q <= '0;
            else                           cnt_q <= cnt_q + 1'b1;
         end
         assign tick = en_i && (cnt_q == LAST);
      end
   endgenerate

   assign rise_o = tick & ~sclk_o;
   assign fall_o = tick &  sclk_o;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    sclk_o <= 1'b0;
      else if (!en_i) sclk_o <= 1'b0;
      else if (tick)  sclk_o <= ~sclk_o;
   end

   // R2: a rise pulse is followed by a high clock, a fall pulse by a low one
   p_rise_high_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rise_o |=> sclk_o);
   p_fall_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fall_o |=> !sclk_o);
endmodule

// File: rtl/ccp_cfg_store.sv
module ccp_cfg_store #(
   parameter int NORM_W = 24,
   parameter int EXT_W  = 48,
   parameter logic [EXT_W-1:0] CFG_DEFAULT = '0
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             wr_lo_i,
   input  logic             wr_all_i,
   input  logic [EXT_W-1:0] d_i,
   output logic [EXT_W-1:0] q_o
);
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q_o <= CFG_DEFAULT;
      else if (wr_all_i) q_o <= d_i;
      else if (wr_lo_i)  q_o[NORM_W-1:0] <= d_i[NORM_W-1:0];
   end

   // R3: a short commit never touches the upper part
   p_upper_kept_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_lo_i && !wr_all_i) |=> $stable(q_o[EXT_W-1:NORM_W]));
endmodule

// File: rtl/cfg_serial_port.sv
module cfg_serial_port #(
   parameter int NORM_W      = 24,
   parameter int EXT_W       = 48,
   parameter int EXT_BIT     = 21,
   parameter int LONG_RD_BIT = 18,
   parameter int HALF_DIV    = 2,
   parameter logic [EXT_W-1:0] CFG_DEFAULT = 48'h0000_0014_4C93
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             sync_i,
   input  logic             reg_sel_i,
   input  logic             rd_wr_i,
   input  logic             txd_i,
   input  logic             dem_rxd_i,
   output logic             sclk_o,
   output logic             rxd_o,
   output logic             busy_o,
   output logic             done_o,
   output logic [EXT_W-1:0] cfg_o
);
   import ccp_pkg::*;

   localparam int CW = $clog2(EXT_W + 2);
   localparam logic [CW-1:0] LEN_N   = CW'(NORM_W);
   localparam logic [CW-1:0] LEN_E   = CW'(EXT_W);
   localparam logic [CW-1:0] LEN_SAT = CW'(EXT_W + 1);
   localparam int PAD = EXT_W - NORM_W;

   generate
      if (EXT_W <= NORM_W) begin : g_bad_len
         $error("EXT_W must exceed NORM_W");
      end
      if (EXT_BIT >= NORM_W || LONG_RD_BIT >= NORM_W) begin : g_bad_bit
         $error("mode bits must lie in the normal part");
      end
      if (HALF_DIV < 1) begin : g_bad_div
         $error("HALF_DIV must be at least 1");
      end
   endgenerate

   logic             req, active_q, start, stop, done_q;
   ccp_dir_e         dir_q;
   logic [CW-1:0]    bits_q, rd_len_q;
   logic [EXT_W-1:0] wsh_q, rsh_q, cfg;
   logic             ext_on, long_rd, clk_en, rise, fall;
   logic             wr_lo, wr_all;

   assign req     = reg_sel_i & sync_i;
   assign start   = req & ~active_q;
   assign stop    = ~req & active_q;
   assign ext_on  = cfg[EXT_BIT];
   assign long_rd = ext_on & cfg[LONG_RD_BIT];
   assign clk_en  = active_q & ~((dir_q == DIR_READ) & (bits_q == rd_len_q));

   ccp_sclk_gen #(.HALF_DIV(HALF_DIV)) u_sclk (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (clk_en),
      .sclk_o (sclk_o),
      .rise_o (rise),
      .fall_o (fall)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         active_q <= 1'b0;
         dir_q    <= DIR_READ;
         bits_q   <= '0;
         rd_len_q <= LEN_N;
         wsh_q    <= '0;
         rsh_q    <= '0;
         done_q   <= 1'b0;
      end else begin
         active_q <= req;
         done_q   <= stop;
         if (start) begin
            dir_q    <= ccp_dir_e'(rd_wr_i);
            bits_q   <= '0;
            rd_len_q <= long_rd ? LEN_E : LEN_N;
            rsh_q    <= long_rd ? cfg : {cfg[NORM_W-1:0], {PAD{1'b0}}};
         end else if (active_q) begin
            if (rise && bits_q != LEN_SAT) bits_q <= bits_q + 1'b1;
            if (rise && dir_q == DIR_WRITE) wsh_q <= {wsh_q[EXT_W-2:0], txd_i};
            if (fall && dir_q == DIR_READ)  rsh_q <= {rsh_q[EXT_W-2:0], 1'b0};
         end
      end
   end

   assign wr_lo  = stop & (dir_q == DIR_WRITE) & (bits_q == LEN_N);
   assign wr_all = stop & (dir_q == DIR_WRITE) & (bits_q == LEN_E) & ext_on;

   ccp_cfg_store #(
      .NORM_W(NORM_W), .EXT_W(EXT_W), .CFG_DEFAULT(CFG_DEFAULT)
   ) u_store (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_lo_i  (wr_lo),
      .wr_all_i (wr_all),
      .d_i      (wsh_q),
      .q_o      (cfg)
   );

   assign cfg_o  = cfg;
   assign busy_o = active_q;
   assign done_o = done_q;
   assign rxd_o  = (active_q && dir_q == DIR_READ) ? rsh_q[EXT_W-1] : dem_rxd_i;

   // R2: no serial clock once the session is closed
   p_idle_clock_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !active_q |=> !sclk_o);
   // R4: the word only moves at the close of a write session
   p_cfg_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(stop && dir_q == DIR_WRITE) |=> $stable(cfg_o));
   // R6: a read never clocks more bits than its length
   p_read_len_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (active_q && dir_q == DIR_READ) |-> bits_q <= rd_len_q);
   // R7: read data holds while the serial clock is high
   p_rxd_steady_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req && active_q && dir_q == DIR_READ && sclk_o && !fall) |=> $stable(rxd_o));
   // R8: asynchronous mode keeps the port idle
   p_async_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !sync_i |=> !busy_o);
   // R9: done follows a busy cycle
   p_done_after_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> $past(busy_o));
endmodule

// File: tb/tb_cfg_serial_port.sv
`timescale 1ns/100ps
module tb_cfg_serial_port;
   localparam logic [47:0] DEF = 48'h0000_0014_4C93;

   logic clk = 1'b0, rst_n = 1'b0;
   logic sync = 1'b1, reg_sel = 1'b0, rd_wr = 1'b1, txd = 1'b0, dem = 1'b0;
   logic sclk_o, rxd_o, busy_o, done_o;
   logic [47:0] cfg_o;

   always #2.5 clk = ~clk;

   cfg_serial_port dut (
      .clk_i(clk), .rst_ni(rst_n), .sync_i(sync), .reg_sel_i(reg_sel),
      .rd_wr_i(rd_wr), .txd_i(txd), .dem_rxd_i(dem), .sclk_o(sclk_o),
      .rxd_o(rxd_o), .busy_o(busy_o), .done_o(done_o), .cfg_o(cfg_o)
   );

   int n_cmp = 0, n_bad = 0;
   int rise_cnt = 0, done_cnt = 0, rxd_viol = 0;
   logic [47:0] model = DEF;
   logic prev_hi = 1'b0, prev_rxd = 1'b0;
   bit finished = 1'b0;

   always @(posedge sclk_o) rise_cnt++;
   always @(posedge clk) if (done_o) done_cnt++;
   always @(posedge clk) begin
      #1;
      if (sclk_o && prev_hi && busy_o && rxd_o !== prev_rxd) rxd_viol++;
      prev_hi  = sclk_o;
      prev_rxd = rxd_o;
   end

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input int n, input logic [63:0] v, input string tag);
      int d0 = done_cnt;
      @(negedge clk);
      txd = v[n-1]; rd_wr = 1'b0; reg_sel = 1'b1;
      for (int i = 0; i < n; i++) begin
         txd = v[n-1-i];
         @(posedge sclk_o); #1;
      end
      reg_sel = 1'b0; rd_wr = 1'b1;
      if (n == 24) model[23:0] = v[23:0];
      else if (n == 48 && model[21]) model = v[47:0];
      repeat (3) @(posedge clk); #1;
      chk(tag, {16'h0, cfg_o}, {16'h0, model});
      chk("R9 one done pulse per write", done_cnt - d0, 1);
   endtask

   task automatic rd(input string tag);
      int len = (model[21] && model[18]) ? 48 : 24;
      int r0 = rise_cnt;
      logic [63:0] got = '0;
      logic [63:0] exp;
      @(negedge clk);
      rd_wr = 1'b1; reg_sel = 1'b1;
      for (int i = 0; i < len; i++) begin
         @(posedge sclk_o); #1;
         got = {got[62:0], rxd_o};
      end
      repeat (12) @(posedge clk); #1;
      chk("R6 rising edge count of read", rise_cnt - r0, len);
      chk("R9 busy held during read", busy_o, 1);
      reg_sel = 1'b0;
      repeat (3) @(posedge clk); #1;
      exp = (len == 48) ? {16'h0, model} : {40'h0, model[23:0]};
      chk(tag, got, exp);
   endtask

   initial begin
      #1_000_000;
      if (!finished) begin
         n_bad++; n_cmp++;
         $display("FAIL watchdog expired actual=hung expected=finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      logic [63:0] s;
      realtime t0, t1;
      int r0;
      repeat (5) @(posedge clk);
      #1;
      // R1 reset state
      chk("R1 cfg default", {16'h0, cfg_o}, {16'h0, DEF});
      chk("R1 sclk low", sclk_o, 0);
      chk("R1 busy low", busy_o, 0);
      rst_n = 1'b1;
      repeat (2) @(posedge clk); #1;
      chk("R1 done low", done_o, 0);

      // R10 and R2: reception mode passes data, no clock
      r0 = rise_cnt;
      dem = 1'b1; #1;
      chk("R10 rxd follows demod 1", rxd_o, 1);
      dem = 1'b0; #1;
      chk("R10 rxd follows demod 0", rxd_o, 0);
      repeat (20) @(posedge clk); #1;
      chk("R2 no clock while idle", rise_cnt - r0, 0);

      // R6: default has bit 18 set but bit 21 clear, so 24 bits
      rd("R6 default readback");

      // R2 half period and first edge
      @(negedge clk);
      rd_wr = 1'b1; reg_sel = 1'b1;
      t0 = $realtime;
      @(posedge sclk_o); t1 = $realtime;
      chk("R2 first edge delay ns", int'(t1 - t0), 2 * 5 + 3);
      t0 = t1;
      @(posedge sclk_o); t1 = $realtime;
      chk("R2 clock period ns", int'(t1 - t0), 4 * 5);
      #1;
      chk("R9 busy during session", busy_o, 1);
      reg_sel = 1'b0;
      repeat (3) @(posedge clk); #1;
      chk("R9 busy after session", busy_o, 0);

      // R3 sweep: walking one through the 24 bits, read back each
      for (int b = 0; b < 24; b++) begin
         wr(24, 64'h1 << b, "R3 walking one write");
         rd("R3 walking one readback");
      end

      // R4/R5: wrong lengths in normal mode, including 48
      wr(24, 64'h00A5_5A3C, "R3 base pattern");
      foreach (s[i]) if (i < 1) ; // no-op keeps s declared use simple
      wr(23, 64'h7F_FFFF, "R4 23 bits dropped");
      wr(25, 64'h1FF_FFFF, "R4 25 bits dropped");
      wr(1, 64'h1, "R4 1 bit dropped");
      wr(48, 64'hFFFF_FFFF_FFFF, "R5 48 bits dropped in normal mode");
      wr(49, 64'h1_FFFF_FFFF_FFFF, "R4 49 bits dropped");

      // enable extended mode with long reads
      wr(24, 64'h0024_1234, "R3 set extended bits");
      rd("R6 long read after enable");

      s = 64'h0123_4567_89AB_CDEF;
      for (int k = 0; k < 6; k++) begin
         s = s * 64'd6364136223846793005 + 64'd1442695040888963407;
         wr(48, (s & 64'h0000_FFFF_FFFF_FFFF) | 64'h24_0000, "R5 48-bit write");
         rd("R5 48-bit readback");
      end
      wr(47, 64'h0, "R4 47 bits dropped in extended mode");
      wr(49, 64'h0, "R4 49 bits dropped in extended mode");
      wr(24, 64'h20_0F0F, "R3 short write keeps upper");
      rd("R6 bit 18 clear gives 24");
      wr(48, 64'hDEAD_BEEF_0000 | 64'h24_1357, "R5 48-bit write again");
      wr(24, 64'h04_5678, "R3 extended off by short write");
      rd("R6 bit 21 clear gives 24");
      wr(48, 64'h1111_2222_3333, "R5 48 bits dropped after disable");

      // R8: asynchronous mode ignores register select
      r0 = rise_cnt;
      @(negedge clk);
      sync = 1'b0; rd_wr = 1'b0; reg_sel = 1'b1;
      for (int i = 0; i < 40; i++) begin
         txd = i[0];
         @(negedge clk);
      end
      chk("R8 busy low in async mode", busy_o, 0);
      chk("R8 no clock in async mode", rise_cnt - r0, 0);
      reg_sel = 1'b0; rd_wr = 1'b1;
      repeat (3) @(posedge clk); #1;
      chk("R8 cfg unchanged in async mode", {16'h0, cfg_o}, {16'h0, model});
      sync = 1'b1;

      chk("R7 rxd changes while clock high", rxd_viol, 0);

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule